// File: doc/BRIEF.md
# Masked Vector Lane Merge Stage

This stage sits at the end of a packed double-precision scaling pipe. It takes the per-lane results computed elsewhere and writes them into a 512-bit destination value. The caller gives a vector length (128, 256 or 512 bits), a per-lane predicate mask, a flag that turns the mask off, and a choice between keeping or zeroing the lanes that the mask disables. Destination bits above the active vector length are always cleared.

The stage also feeds the lane datapath. In the same cycle as the request, it sends the second source operand to the lanes, either sliced per lane or with its low 64 bits broadcast when the operand comes from memory. It also picks the rounding mode the lanes must use: an embedded static mode replaces the global mode only for 512-bit register-sourced forms with the broadcast/control bit set.

Exception flags from the lanes are reduced into one flag word, and only lanes that actually write a result contribute. The merged destination, the flag word and a valid strobe are registered, so the result appears one cycle after the request.

Top module: `lane_merge_stage`

## Requirements
- R1: `vlen_sel` picks the active lane count: 2'b00 gives 2 lanes (128 bits), 2'b01 gives 4 lanes (256 bits), 2'b10 and 2'b11 give 8 lanes (512 bits). Lane j occupies bits [64j+63:64j] of every 512-bit bus.
- R2: An active lane whose `lane_mask` bit is 1, or any active lane when `no_mask` is 1, takes its value from `lane_res`.
- R3: An active lane that the mask disables keeps its `old_dst` value when `zero_mode` is 0.
- R4: An active lane that the mask disables becomes zero when `zero_mode` is 1.
- R5: Every `new_dst` bit from 64 times the active lane count up to bit 511 is zero, whatever the mask and mode are.
- R6: In the cycle of the request, when `bcast` is 1 and `src2_is_mem` is 1, every lane of `lane_src2` equals `src2[63:0]`. Otherwise lane j of `lane_src2` equals `src2[64j+63:64j]`.
- R7: `rc_sel` equals `rc_embed` when the vector length is 512 bits, `bcast` is 1 and `src2_is_mem` is 0. In all other cases it equals `rc_global`.
- R8: `out_flags` is the bitwise OR of the 5-bit flag groups `lane_flags[5j+4:5j]` of the lanes that write a result under R2. Disabled and inactive lanes contribute nothing.
- R9: `out_valid` is `in_valid` delayed by one clock. `new_dst` and `out_flags` change only in the cycle after a request and hold otherwise.
- R10: After reset, `out_valid` is 0, `new_dst` is all zero and `out_flags` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| vlen_sel | input | 2 | Vector length code (R1) |
| lane_mask | input | 8 | Per-lane predicate mask |
| no_mask | input | 1 | 1: ignore the mask, write every active lane |
| zero_mode | input | 1 | 1: zero disabled lanes, 0: keep them |
| bcast | input | 1 | Broadcast / static-rounding control bit |
| src2_is_mem | input | 1 | 1: second source comes from memory |
| rc_embed | input | 2 | Embedded static rounding mode |
| rc_global | input | 2 | Global rounding mode |
| old_dst | input | 512 | Previous destination value |
| src2 | input | 512 | Second source operand |
| lane_res | input | 512 | Per-lane results from the lanes |
| lane_flags | input | 40 | Per-lane exception flags, 5 bits per lane |
| lane_src2 | output | 512 | Second source routed to each lane |
| rc_sel | output | 2 | Rounding mode for the lanes |
| out_valid | output | 1 | Result strobe |
| new_dst | output | 512 | Merged destination value |
| out_flags | output | 5 | Reduced exception flags |

## Verification
A wrong lane enable or active-lane count shows up one cycle after the request as a 64-bit lane of `new_dst` holding a result, an old value or zero in the wrong place, or as stray flag bits in `out_flags`. Bad operand routing or a wrong rounding choice shows up on `lane_src2` and `rc_sel` in the same cycle as the request. The bench therefore checks every lane of every transaction on its own and also checks that the registered outputs hold between requests.

// File: rtl/lms_pkg.sv
package lms_pkg;

  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_512R = 2'b11
  } vlen_e;

  // Number of active lanes for a length code, bounded by the lanes built.
  function automatic int active_lanes(input logic [1:0] sel, input int max_lanes);
    int n;
    case (sel)
      VL_128:  n = 2;
      VL_256:  n = 4;
      default: n = 8;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

  function automatic logic is_full_width(input logic [1:0] sel);
    return (sel == VL_512) || (sel == VL_512R);
  endfunction

endpackage

// File: rtl/lms_src_route.sv
module lms_src_route #(
  parameter int LANE_W = 64,
  parameter int NLANES = 8
) (
  input  logic [LANE_W*NLANES-1:0] src2,
  input  logic                     bcast,
  input  logic                     src2_is_mem,
  output logic [LANE_W*NLANES-1:0] lane_src2
);

  logic splat;

  always_comb begin
    splat = bcast & src2_is_mem;
  end

  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    always_comb begin
      if (splat) begin
        lane_src2[j*LANE_W +: LANE_W] = src2[LANE_W-1:0];
      end else begin
        lane_src2[j*LANE_W +: LANE_W] = src2[j*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/lms_round_pick.sv
module lms_round_pick #(
  parameter int RC_W = 2
) (
  input  logic [1:0]      vlen_sel,
  input  logic            bcast,
  input  logic            src2_is_mem,
  input  logic [RC_W-1:0] rc_embed,
  input  logic [RC_W-1:0] rc_global,
  output logic [RC_W-1:0] rc_sel
);
  import lms_pkg::*;

  logic use_embed;

  always_comb begin
    use_embed = is_full_width(vlen_sel) & bcast & ~src2_is_mem;
    rc_sel    = use_embed ? rc_embed : rc_global;
  end

endmodule

// File: rtl/lms_lane_ctl.sv
module lms_lane_ctl #(
  parameter int NLANES = 8
) (
  input  logic [1:0]        vlen_sel,
  input  logic [NLANES-1:0] lane_mask,
  input  logic              no_mask,
  output logic [NLANES-1:0] lane_act,
  output logic [NLANES-1:0] lane_wr
);
  import lms_pkg::*;

  int n_act;

  always_comb begin
    n_act = active_lanes(vlen_sel, NLANES);
  end

  for (genvar j = 0; j < NLANES; j++) begin : g_ctl
    always_comb begin
      lane_act[j] = (j < n_act);
      lane_wr[j]  = lane_act[j] & (no_mask | lane_mask[j]);
    end
  end

endmodule

// File: rtl/lms_merge.sv
module lms_merge #(
  parameter int LANE_W = 64,
  parameter int NLANES = 8,
  parameter int FLAG_W = 5
) (
  input  logic [NLANES-1:0]        lane_act,
  input  logic [NLANES-1:0]        lane_wr,
  input  logic                     zero_mode,
  input  logic [LANE_W*NLANES-1:0] old_dst,
  input  logic [LANE_W*NLANES-1:0] lane_res,
  input  logic [FLAG_W*NLANES-1:0] lane_flags,
  output logic [LANE_W*NLANES-1:0] merged,
  output logic [FLAG_W-1:0]        flags
);

  logic [FLAG_W-1:0] gated [NLANES];

  for (genvar j = 0; j < NLANES; j++) begin : g_mrg
    always_comb begin
      if (!lane_act[j]) begin
        merged[j*LANE_W +: LANE_W] = '0;
      end else if (lane_wr[j]) begin
        merged[j*LANE_W +: LANE_W] = lane_res[j*LANE_W +: LANE_W];
      end else if (zero_mode) begin
        merged[j*LANE_W +: LANE_W] = '0;
      end else begin
        merged[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
      end
      gated[j] = lane_wr[j] ? lane_flags[j*FLAG_W +: FLAG_W] : '0;
    end
  end

  always_comb begin
    flags = '0;
    for (int j = 0; j < NLANES; j++) begin
      flags = flags | gated[j];
    end
  end

endmodule

// File: rtl/lane_merge_stage.sv
module lane_merge_stage #(
  parameter int LANE_W = 64,
  parameter int NLANES = 8,
  parameter int FLAG_W = 5,
  parameter int RC_W   = 2,
  localparam int DST_W = LANE_W * NLANES,
  localparam int FLG_W = FLAG_W * NLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        vlen_sel,
  input  logic [NLANES-1:0] lane_mask,
  input  logic              no_mask,
  input  logic              zero_mode,
  input  logic              bcast,
  input  logic              src2_is_mem,
  input  logic [RC_W-1:0]   rc_embed,
  input  logic [RC_W-1:0]   rc_global,
  input  logic [DST_W-1:0]  old_dst,
  input  logic [DST_W-1:0]  src2,
  input  logic [DST_W-1:0]  lane_res,
  input  logic [FLG_W-1:0]  lane_flags,
  output logic [DST_W-1:0]  lane_src2,
  output logic [RC_W-1:0]   rc_sel,
  output logic              out_valid,
  output logic [DST_W-1:0]  new_dst,
  output logic [FLAG_W-1:0] out_flags
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  always_comb begin
    rst_q_n = rst_sync[1];
  end

  // Lane-facing combinational paths.
  lms_src_route #(.LANE_W(LANE_W), .NLANES(NLANES)) u_route (
    .src2        (src2),
    .bcast       (bcast),
    .src2_is_mem (src2_is_mem),
    .lane_src2   (lane_src2)
  );

  lms_round_pick #(.RC_W(RC_W)) u_round (
    .vlen_sel    (vlen_sel),
    .bcast       (bcast),
    .src2_is_mem (src2_is_mem),
    .rc_embed    (rc_embed),
    .rc_global   (rc_global),
    .rc_sel      (rc_sel)
  );

  // Lane enables and merge.
  logic [NLANES-1:0] lane_act;
  logic [NLANES-1:0] lane_wr;
  logic [DST_W-1:0]  merged;
  logic [FLAG_W-1:0] flags_red;

  lms_lane_ctl #(.NLANES(NLANES)) u_ctl (
    .vlen_sel  (vlen_sel),
    .lane_mask (lane_mask),
    .no_mask   (no_mask),
    .lane_act  (lane_act),
    .lane_wr   (lane_wr)
  );

  lms_merge #(.LANE_W(LANE_W), .NLANES(NLANES), .FLAG_W(FLAG_W)) u_merge (
    .lane_act   (lane_act),
    .lane_wr    (lane_wr),
    .zero_mode  (zero_mode),
    .old_dst    (old_dst),
    .lane_res   (lane_res),
    .lane_flags (lane_flags),
    .merged     (merged),
    .flags      (flags_red)
  );

  // Output register: next-state logic.
  logic              valid_q, valid_d;
  logic [DST_W-1:0]  dst_q, dst_d;
  logic [FLAG_W-1:0] flg_q, flg_d;
  logic              load_en;

  always_comb begin
    load_en = in_valid;
    valid_d = in_valid;
    dst_d   = merged;
    flg_d   = flags_red;
  end

  // Output register: state.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dst_q <= '0;
      flg_q <= '0;
    end else if (load_en) begin
      dst_q <= dst_d;
      flg_q <= flg_d;
    end
  end

  always_comb begin
    out_valid = valid_q;
    new_dst   = dst_q;
    out_flags = flg_q;
  end

endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
  parameter int LANE_W = 64,
  parameter int NLANES = 8,
  parameter int FLAG_W = 5,
  parameter int RC_W   = 2,
  localparam int DST_W = LANE_W * NLANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        vlen_sel,
  input logic [NLANES-1:0] lane_mask,
  input logic              no_mask,
  input logic              zero_mode,
  input logic              bcast,
  input logic              src2_is_mem,
  input logic [RC_W-1:0]   rc_embed,
  input logic [RC_W-1:0]   rc_global,
  input logic [LANE_W-1:0] old_lo,
  input logic [LANE_W-1:0] src2_lo,
  input logic [LANE_W-1:0] lane_src2_top,
  input logic [RC_W-1:0]   rc_sel,
  input logic              out_valid,
  input logic [DST_W-1:0]  new_dst,
  input logic [FLAG_W-1:0] out_flags
);

  // R9: one cycle from request to result strobe
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R5: a 128-bit request leaves everything above lane 1 clear
  p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vlen_sel == 2'b00) |=> ((new_dst >> (2*LANE_W)) == '0));

  // R3: disabled lane 0 in merging mode keeps the old value
  p_merge_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_mask && !lane_mask[0] && !zero_mode)
      |=> (new_dst[LANE_W-1:0] == $past(old_lo)));

  // R4: disabled lane 0 in zeroing mode is cleared
  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_mask && !lane_mask[0] && zero_mode)
      |=> (new_dst[LANE_W-1:0] == '0));

  // R8: a fully masked request reports no flags
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_mask && lane_mask == '0) |=> (out_flags == '0));

  // R6: memory broadcast reaches the highest lane
  p_bcast_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast && src2_is_mem) |-> (lane_src2_top == src2_lo));

  // R7: register-sourced forms below 512 bits use the global mode
  p_round_global_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vlen_sel[1] == 1'b0 || !bcast || src2_is_mem) |-> (rc_sel == rc_global));

  p_round_embed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vlen_sel[1] && bcast && !src2_is_mem) |-> (rc_sel == rc_embed));

endmodule

bind lane_merge_stage lms_checker #(
  .LANE_W (LANE_W),
  .NLANES (NLANES),
  .FLAG_W (FLAG_W),
  .RC_W   (RC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .in_valid      (in_valid),
  .vlen_sel      (vlen_sel),
  .lane_mask     (lane_mask),
  .no_mask       (no_mask),
  .zero_mode     (zero_mode),
  .bcast         (bcast),
  .src2_is_mem   (src2_is_mem),
  .rc_embed      (rc_embed),
  .rc_global     (rc_global),
  .old_lo        (old_dst[LANE_W-1:0]),
  .src2_lo       (src2[LANE_W-1:0]),
  .lane_src2_top (lane_src2[LANE_W*NLANES-1 -: LANE_W]),
  .rc_sel        (rc_sel),
  .out_valid     (out_valid),
  .new_dst       (new_dst),
  .out_flags     (out_flags)
);

// File: tb/lane_merge_stage_test.sv
module lane_merge_stage_test;

  localparam int LW = 64;
  localparam int NL = 8;
  localparam int FW = 5;
  localparam int DW = LW * NL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    vlen_sel;
  logic [NL-1:0] lane_mask;
  logic          no_mask, zero_mode, bcast, src2_is_mem;
  logic [1:0]    rc_embed, rc_global;
  logic [DW-1:0] old_dst, src2, lane_res;
  logic [FW*NL-1:0] lane_flags;
  logic [DW-1:0] lane_src2;
  logic [1:0]    rc_sel;
  logic          out_valid;
  logic [DW-1:0] new_dst;
  logic [FW-1:0] out_flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  lane_merge_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
    .lane_mask(lane_mask), .no_mask(no_mask), .zero_mode(zero_mode),
    .bcast(bcast), .src2_is_mem(src2_is_mem), .rc_embed(rc_embed),
    .rc_global(rc_global), .old_dst(old_dst), .src2(src2),
    .lane_res(lane_res), .lane_flags(lane_flags), .lane_src2(lane_src2),
    .rc_sel(rc_sel), .out_valid(out_valid), .new_dst(new_dst),
    .out_flags(out_flags)
  );

  function automatic int lanes_of(input logic [1:0] s);
    if (s == 2'b00) return 2;
    if (s == 2'b01) return 4;
    return 8;
  endfunction

  function automatic logic [DW-1:0] rnd_wide();
    logic [DW-1:0] v;
    for (int k = 0; k < DW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request: drive, check lane-side outputs, then the registered result.
  task automatic apply(input logic [1:0] vl, input logic [NL-1:0] m,
                       input logic nm, input logic zm, input logic bc,
                       input logic mem);
    logic [DW-1:0] e_src, e_dst;
    logic [FW-1:0] e_flg;
    logic [1:0]    e_rc;
    int            n;
    in_valid = 1'b1; vlen_sel = vl; lane_mask = m; no_mask = nm;
    zero_mode = zm; bcast = bc; src2_is_mem = mem;
    rc_embed = 2'($urandom); rc_global = 2'($urandom);
    old_dst = rnd_wide(); src2 = rnd_wide(); lane_res = rnd_wide();
    lane_flags = {8'($urandom), 32'($urandom)};
    n = lanes_of(vl);
    e_flg = '0;
    e_rc = (vl[1] && bc && !mem) ? rc_embed : rc_global;
    for (int j = 0; j < NL; j++)
      e_src[j*LW +: LW] = (bc && mem) ? src2[LW-1:0] : src2[j*LW +: LW];
    #1;
    check("R6 lane_src2", lane_src2, e_src);
    check("R7 rc_sel", DW'(rc_sel), DW'(e_rc));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 out_valid", DW'(out_valid), DW'(1));
    for (int j = 0; j < NL; j++) begin
      logic [LW-1:0] e;
      string r;
      if (j >= n) begin
        e = '0; r = "R5 above length";
      end else if (nm || m[j]) begin
        e = lane_res[j*LW +: LW]; r = "R2 written lane";
        e_flg = e_flg | lane_flags[j*FW +: FW];
      end else if (zm) begin
        e = '0; r = "R4 zeroed lane";
      end else begin
        e = old_dst[j*LW +: LW]; r = "R3 kept lane";
      end
      e_dst[j*LW +: LW] = e;
      check($sformatf("%s %0d (R1 n=%0d)", r, j, n),
            DW'(new_dst[j*LW +: LW]), DW'(e));
    end
    check("R8 out_flags", DW'(out_flags), DW'(e_flg));
  endtask

  initial begin
    logic [DW-1:0] held;
    logic [FW-1:0] held_f;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; vlen_sel = '0; lane_mask = '0;
    no_mask = 0; zero_mode = 0; bcast = 0; src2_is_mem = 0;
    rc_embed = '0; rc_global = '0; old_dst = '0; src2 = '0;
    lane_res = '0; lane_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", DW'(out_valid), '0);
    check("R10 new_dst", new_dst, '0);
    check("R10 out_flags", DW'(out_flags), '0);

    // Directed corners
    apply(2'b10, 8'hFF, 0, 0, 0, 0);  // R2 all written
    apply(2'b10, 8'h00, 0, 0, 0, 0);  // R3 all kept, R8 no flags
    apply(2'b10, 8'h00, 0, 1, 0, 0);  // R4 all zeroed
    apply(2'b00, 8'h00, 1, 0, 1, 1);  // R1/R5 128-bit, broadcast
    apply(2'b01, 8'hA5, 0, 1, 1, 0);  // R7 no override at 256
    apply(2'b10, 8'h5A, 0, 0, 1, 0);  // R7 override at 512 register form
    apply(2'b11, 8'h3C, 0, 1, 1, 1);  // R1 code 3 is 512, R6 broadcast
    apply(2'b00, 8'hFC, 0, 0, 0, 0);  // R8 masks beyond length ignored

    // Random mix
    for (int t = 0; t < 200; t++)
      apply(2'($urandom), 8'($urandom), 1'($urandom % 4 == 0),
            1'($urandom), 1'($urandom), 1'($urandom));

    // R9: outputs hold without a request
    held = new_dst; held_f = out_flags;
    old_dst = rnd_wide(); lane_res = rnd_wide(); lane_flags = '1;
    no_mask = 1'b1; vlen_sel = 2'b10;
    repeat (3) @(negedge clk);
    check("R9 idle valid", DW'(out_valid), '0);
    check("R9 hold new_dst", new_dst, held);
    check("R9 hold out_flags", DW'(out_flags), DW'(held_f));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule